// File: doc/BRIEF.md
# Bank Register Address Extender

This block widens the 16-bit addresses of a small 8-bit processor core to 24 bits. It holds four 8-bit bank registers, numbered 0 to 3. On every bus cycle the block picks one of them, and that register's value becomes the top byte of the outgoing address. Bank 0 is the home bank. It serves every code cycle and every data cycle unless something has chosen another bank.

Another bank is chosen in one of two ways. The first is a one-byte prefix opcode, fetched just before an instruction. The second is one of six dedicated load or store opcodes, which carry a fixed bank choice of their own. In both cases the chosen bank applies only to the final data-access cycle of that instruction. Operand fetches, pointer fetches and all earlier data cycles keep using bank 0.

The core reports each cycle to the block through four signals: an opcode-fetch strobe with the opcode byte, a code/data flag and a final-cycle flag. The bank registers are loaded through a simple write port. The address output is combinational, so it responds in the same cycle as the core's address.

Top module: `bank_addr_ext`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every bank register reads zero, so `bus_addr` equals `{8'h00, core_addr}`.
- R2: A cycle with `bank_wr_en` high loads `bank_wr_data` into the bank picked by `bank_wr_sel` (0 to 3). The new value first appears on `bus_addr` in the following cycle. An address formed in the write cycle itself still uses the old value.
- R3: In every cycle with `is_code` high or `op_fetch` high, the top byte of `bus_addr` is bank 0. This holds even while a bank choice is pending.
- R4: When neither a prefix nor a dedicated opcode has chosen a bank, the final data cycle (`is_code` low, `last_cycle` high) also uses bank 0.
- R5: Fetching prefix opcode 8'h83 chooses bank 1, 8'hC3 chooses bank 2 and 8'h43 chooses bank 3. The choice is used on the final data cycle of the instruction whose opcode is fetched next.
- R6: Data cycles with `last_cycle` low use bank 0, even within an instruction that has a bank choice.
- R7: After a final data cycle, the bank choice is cleared. A further final data cycle, or the next instruction that has no prefix, uses bank 0.
- R8: When a prefix follows another prefix, the later prefix decides the bank.
- R9: The dedicated load opcodes (defaults 8'h0B, 8'h1B, 8'h2B) choose bank 2, and the dedicated store opcodes (defaults 8'h3B, 8'h4B, 8'h5B) choose bank 1. No prefix is needed.
- R10: When a prefix comes before a dedicated opcode, the prefix's bank takes priority over the dedicated opcode's bank.
- R11: Fetching an opcode that is neither a prefix nor a dedicated opcode, with no prefix armed, discards any bank choice that was never used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_addr | input | 16 | Address from the core |
| op_fetch | input | 1 | High on an opcode-fetch cycle |
| op_byte | input | 8 | Opcode byte fetched in this cycle |
| is_code | input | 1 | High for a code cycle, low for a data cycle |
| last_cycle | input | 1 | High on the final cycle of an instruction |
| bank_wr_en | input | 1 | Write strobe for the bank registers |
| bank_wr_sel | input | 2 | Index of the bank register to write |
| bank_wr_data | input | 8 | Value to write |
| bus_addr | output | 24 | Extended address: bank byte, then `core_addr` |

## Verification
The pending bank choice is hidden state. If it is wrong, nothing shows at the ports until the next final data cycle, where the top address byte carries the wrong register. That may be several cycles after the fault. For this reason every test drives a complete instruction up to its final data cycle and then one more, and it also inspects the earlier cycles. A choice that leaks into an operand fetch, or that outlives its instruction, shows up at once as a wrong top byte in that cycle. An error in a bank register shows up on the first code cycle after the write that caused it, for bank 0. For the other banks, it shows up on the first final data cycle that selects that bank.

// File: rtl/bank_ext_pkg.sv
package bank_ext_pkg;

  // Index of a bank register
  typedef enum logic [1:0] {
    BK0 = 2'd0,
    BK1 = 2'd1,
    BK2 = 2'd2,
    BK3 = 2'd3
  } bank_id_t;

  // Class of a fetched opcode, as this block sees it
  typedef enum logic [1:0] {
    OPK_PLAIN  = 2'd0,
    OPK_PREFIX = 2'd1,
    OPK_DEDIC  = 2'd2
  } op_kind_t;

endpackage

// File: rtl/bank_op_classify.sv
module bank_op_classify
  import bank_ext_pkg::*;
#(
  parameter int         OP_W      = 8,
  parameter logic [7:0] PFX_K1    = 8'h83,
  parameter logic [7:0] PFX_K2    = 8'hC3,
  parameter logic [7:0] PFX_K3    = 8'h43,
  parameter logic [7:0] LD_ABS    = 8'h0B,
  parameter logic [7:0] LD_XIND   = 8'h1B,
  parameter logic [7:0] LD_INDY   = 8'h2B,
  parameter logic [7:0] ST_ABS    = 8'h3B,
  parameter logic [7:0] ST_XIND   = 8'h4B,
  parameter logic [7:0] ST_INDY   = 8'h5B
) (
  input  logic [OP_W-1:0] op_byte,
  output op_kind_t        kind,
  output bank_id_t        bank
);

  logic is_pfx1, is_pfx2, is_pfx3;
  logic is_load, is_store;

  always_comb begin
    is_pfx1  = (op_byte == PFX_K1);
    is_pfx2  = (op_byte == PFX_K2);
    is_pfx3  = (op_byte == PFX_K3);
    is_load  = (op_byte == LD_ABS) || (op_byte == LD_XIND) || (op_byte == LD_INDY);
    is_store = (op_byte == ST_ABS) || (op_byte == ST_XIND) || (op_byte == ST_INDY);
  end

  // Prefix codes take priority over the dedicated opcodes
  always_comb begin
    kind = OPK_PLAIN;
    bank = BK0;
    if (is_pfx1) begin
      kind = OPK_PREFIX;
      bank = BK1;
    end else if (is_pfx2) begin
      kind = OPK_PREFIX;
      bank = BK2;
    end else if (is_pfx3) begin
      kind = OPK_PREFIX;
      bank = BK3;
    end else if (is_load) begin
      kind = OPK_DEDIC;
      bank = BK2;
    end else if (is_store) begin
      kind = OPK_DEDIC;
      bank = BK1;
    end
  end

endmodule

// File: rtl/bank_sel_tracker.sv
module bank_sel_tracker
  import bank_ext_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     op_fetch,
  input  op_kind_t kind,
  input  bank_id_t kind_bank,
  input  logic     data_final,
  output logic     sel_active,
  output bank_id_t sel_bank
);

  logic     armed_q, armed_d;
  logic     act_q, act_d;
  bank_id_t sel_q, sel_d;
  logic     st_en;

  // The state moves only on opcode fetches and final data cycles
  always_comb begin
    st_en = op_fetch || data_final;
  end

  always_comb begin
    armed_d = armed_q;
    act_d   = act_q;
    sel_d   = sel_q;
    if (op_fetch) begin
      if (kind == OPK_PREFIX) begin
        // A new prefix replaces whatever an earlier prefix chose
        armed_d = 1'b1;
        act_d   = 1'b0;
        sel_d   = kind_bank;
      end else if (armed_q) begin
        // The prefixed instruction starts; the prefix bank is kept
        armed_d = 1'b0;
        act_d   = 1'b1;
      end else if (kind == OPK_DEDIC) begin
        act_d   = 1'b1;
        sel_d   = kind_bank;
      end else begin
        act_d   = 1'b0;
        sel_d   = BK0;
      end
    end else if (data_final) begin
      act_d = 1'b0;
      sel_d = BK0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      act_q   <= 1'b0;
      sel_q   <= BK0;
    end else if (st_en) begin
      armed_q <= armed_d;
      act_q   <= act_d;
      sel_q   <= sel_d;
    end
  end

  assign sel_active = act_q;
  assign sel_bank   = sel_q;

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 4,
  localparam int SEL_W    = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [BANK_W-1:0]           wr_data,
  input  logic [SEL_W-1:0]            rd_idx,
  output logic [BANK_W-1:0]           rd_data,
  output logic [NUM_BANKS*BANK_W-1:0] bank_flat
);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic              en;
    logic [BANK_W-1:0] q, d;

    always_comb begin
      en = wr_en && (wr_sel == SEL_W'(i));
      d  = en ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (en) q <= d;
    end

    assign bank_flat[i*BANK_W +: BANK_W] = q;
  end

  // Reads see the registered values, so a write shows up one cycle later
  assign rd_data = bank_flat[rd_idx*BANK_W +: BANK_W];

endmodule

// File: rtl/bank_addr_ext.sv
module bank_addr_ext
  import bank_ext_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         BANK_W  = 8,
  parameter int         OP_W    = 8,
  parameter logic [7:0] LD_ABS  = 8'h0B,
  parameter logic [7:0] LD_XIND = 8'h1B,
  parameter logic [7:0] LD_INDY = 8'h2B,
  parameter logic [7:0] ST_ABS  = 8'h3B,
  parameter logic [7:0] ST_XIND = 8'h4B,
  parameter logic [7:0] ST_INDY = 8'h5B
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        core_addr,
  input  logic                     op_fetch,
  input  logic [OP_W-1:0]          op_byte,
  input  logic                     is_code,
  input  logic                     last_cycle,
  input  logic                     bank_wr_en,
  input  logic [1:0]               bank_wr_sel,
  input  logic [BANK_W-1:0]        bank_wr_data,
  output logic [ADDR_W+BANK_W-1:0] bus_addr
);

  localparam int NUM_BANKS = 4;
  localparam int SEL_W     = $clog2(NUM_BANKS);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  op_kind_t                    op_kind;
  bank_id_t                    op_bank;
  logic                        data_final;
  logic                        sel_act;
  bank_id_t                    sel_bank;
  logic [SEL_W-1:0]            rd_idx;
  logic [BANK_W-1:0]           rd_val;
  logic [NUM_BANKS*BANK_W-1:0] bank_flat;

  always_comb begin
    data_final = !is_code && last_cycle && !op_fetch;
  end

  // Only a final data cycle may use a bank other than bank 0
  always_comb begin
    rd_idx = (sel_act && data_final) ? SEL_W'(sel_bank) : SEL_W'(BK0);
  end

  bank_op_classify #(
    .OP_W   (OP_W),
    .LD_ABS (LD_ABS),
    .LD_XIND(LD_XIND),
    .LD_INDY(LD_INDY),
    .ST_ABS (ST_ABS),
    .ST_XIND(ST_XIND),
    .ST_INDY(ST_INDY)
  ) u_classify (
    .op_byte(op_byte),
    .kind   (op_kind),
    .bank   (op_bank)
  );

  bank_sel_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op_fetch  (op_fetch),
    .kind      (op_kind),
    .kind_bank (op_bank),
    .data_final(data_final),
    .sel_active(sel_act),
    .sel_bank  (sel_bank)
  );

  bank_regfile #(
    .BANK_W   (BANK_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bank_wr_en && rst_sync_n),
    .wr_sel   (bank_wr_sel),
    .wr_data  (bank_wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_val),
    .bank_flat(bank_flat)
  );

  assign bus_addr = {rd_val, core_addr};

endmodule

// File: rtl/bank_addr_ext_chk.sv
module bank_addr_ext_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rst_sync_n,
  input logic                     op_fetch,
  input logic                     is_code,
  input logic                     last_cycle,
  input logic                     bank_wr_en,
  input logic [1:0]               bank_wr_sel,
  input logic [BANK_W-1:0]        bank_wr_data,
  input logic [ADDR_W+BANK_W-1:0] bus_addr,
  input logic [4*BANK_W-1:0]      bank_flat,
  input logic                     sel_act
);

  localparam int TOP = ADDR_W + BANK_W - 1;

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> bus_addr[TOP -: BANK_W] == '0);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bank_wr_en |=> bank_flat[$past(bank_wr_sel)*BANK_W +: BANK_W] == $past(bank_wr_data));

  assert_code_uses_k0_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (is_code || op_fetch) |-> bus_addr[TOP -: BANK_W] == bank_flat[BANK_W-1:0]);

  assert_nonfinal_k0_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!is_code && !last_cycle) |-> bus_addr[TOP -: BANK_W] == bank_flat[BANK_W-1:0]);

  assert_choice_cleared_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_fetch && !is_code && last_cycle) |=> !sel_act);

endmodule

bind bank_addr_ext bank_addr_ext_chk #(
  .ADDR_W(ADDR_W),
  .BANK_W(BANK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .op_fetch    (op_fetch),
  .is_code     (is_code),
  .last_cycle  (last_cycle),
  .bank_wr_en  (bank_wr_en),
  .bank_wr_sel (bank_wr_sel),
  .bank_wr_data(bank_wr_data),
  .bus_addr    (bus_addr),
  .bank_flat   (bank_flat),
  .sel_act     (sel_act)
);

// File: tb/tb_bank_addr_ext.sv
module tb_bank_addr_ext;

  logic        clk;
  logic        rst_n;
  logic [15:0] core_addr;
  logic        op_fetch;
  logic [7:0]  op_byte;
  logic        is_code;
  logic        last_cycle;
  logic        bank_wr_en;
  logic [1:0]  bank_wr_sel;
  logic [7:0]  bank_wr_data;
  logic [23:0] bus_addr;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned cyc   = 0;
  logic [7:0]  kv [4];

  bank_addr_ext dut (
    .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .op_fetch(op_fetch),
    .op_byte(op_byte), .is_code(is_code), .last_cycle(last_cycle),
    .bank_wr_en(bank_wr_en), .bank_wr_sel(bank_wr_sel),
    .bank_wr_data(bank_wr_data), .bus_addr(bus_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one cycle at the falling edge and sample the output 2 ns later
  task automatic step(input logic f, input logic [7:0] op, input logic code,
                      input logic last, input logic [15:0] a, output logic [23:0] got);
    @(negedge clk);
    op_fetch = f; op_byte = op; is_code = code; last_cycle = last; core_addr = a;
    #2;
    got = bus_addr;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    logic [23:0] g;
    @(negedge clk);
    bank_wr_en = 1'b1; bank_wr_sel = s; bank_wr_data = d;
    @(negedge clk);
    bank_wr_en = 1'b0;
    kv[s] = d;
    step(1'b0, 8'hEA, 1'b1, 1'b0, 16'h0000, g);
  endtask

  // An instruction: opcode fetch, operand fetch, non-final data cycle, final data cycle
  task automatic instr(input string req, input logic [7:0] op, input logic [7:0] exp_bank);
    logic [23:0] g;
    step(1'b1, op, 1'b1, 1'b0, 16'h4000, g);
    chk({req, " R3 fetch"}, g, {kv[0], 16'h4000});
    step(1'b0, 8'h00, 1'b1, 1'b0, 16'h4001, g);
    chk({req, " R3 operand"}, g, {kv[0], 16'h4001});
    step(1'b0, 8'h00, 1'b0, 1'b0, 16'h0080, g);
    chk({req, " R6 pointer"}, g, {kv[0], 16'h0080});
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h1234, g);
    chk({req, " final"}, g, {exp_bank, 16'h1234});
  endtask

  task automatic pfx(input logic [7:0] p);
    logic [23:0] g;
    step(1'b1, p, 1'b1, 1'b0, 16'h3FFF, g);
    chk("R3 prefix fetch", g, {kv[0], 16'h3FFF});
  endtask

  task automatic t_reset;
    logic [23:0] g;
    rst_n = 1'b0;
    op_fetch = 0; op_byte = 0; is_code = 1; last_cycle = 0; core_addr = 16'hBEEF;
    bank_wr_en = 0; bank_wr_sel = 0; bank_wr_data = 0;
    for (int i = 0; i < 4; i++) kv[i] = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1 in reset", bus_addr, 24'h00BEEF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h5555, g);
    chk("R1 after reset", g, 24'h005555);
  endtask

  task automatic t_write;
    logic [23:0] g;
    wr(2'd0, 8'h10); wr(2'd1, 8'h21); wr(2'd2, 8'h32); wr(2'd3, 8'h43);
    step(1'b0, 8'h00, 1'b1, 1'b0, 16'h0100, g);
    chk("R2 bank0 written", g, 24'h100100);
    pfx(8'h83); instr("R2 bank1 value", 8'hAD, 8'h21);
  endtask

  task automatic t_plain;
    instr("R4 plain", 8'hAD, kv[0]);
    instr("R4 plain again", 8'h8D, kv[0]);
  endtask

  task automatic t_prefix;
    logic [23:0] g;
    pfx(8'h83); instr("R5 pfx83", 8'hAD, kv[1]);
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h2222, g);
    chk("R7 second final", g, {kv[0], 16'h2222});
    pfx(8'hC3); instr("R5 pfxC3", 8'hB1, kv[2]);
    pfx(8'h43); instr("R5 pfx43", 8'h91, kv[3]);
    instr("R7 next unprefixed", 8'hAD, kv[0]);
  endtask

  task automatic t_double;
    pfx(8'h83); pfx(8'hC3); instr("R8 later prefix wins", 8'hAD, kv[2]);
    pfx(8'h43); pfx(8'h83); instr("R8 later prefix wins b", 8'hAD, kv[1]);
  endtask

  task automatic t_dedic;
    instr("R9 ld abs",  8'h0B, kv[2]);
    instr("R9 ld xind", 8'h1B, kv[2]);
    instr("R9 ld indy", 8'h2B, kv[2]);
    instr("R9 st abs",  8'h3B, kv[1]);
    instr("R9 st xind", 8'h4B, kv[1]);
    instr("R9 st indy", 8'h5B, kv[1]);
  endtask

  task automatic t_pfx_dedic;
    pfx(8'h43); instr("R10 prefix over load", 8'h0B, kv[3]);
    pfx(8'h83); instr("R10 prefix over load b", 8'h2B, kv[1]);
  endtask

  task automatic t_abandon;
    logic [23:0] g;
    step(1'b1, 8'h3B, 1'b1, 1'b0, 16'h0200, g);
    step(1'b0, 8'h00, 1'b1, 1'b0, 16'h0201, g);
    instr("R11 unused dedicated dropped", 8'hEA, kv[0]);
    pfx(8'hC3);
    step(1'b1, 8'hEA, 1'b1, 1'b0, 16'h0300, g);
    instr("R11 unused prefix dropped", 8'hAD, kv[0]);
  endtask

  task automatic t_collide;
    logic [23:0] g;
    pfx(8'h83);
    step(1'b1, 8'hAD, 1'b1, 1'b0, 16'h0400, g);
    @(negedge clk);
    op_fetch = 0; is_code = 0; last_cycle = 1; core_addr = 16'h0ABC;
    bank_wr_en = 1; bank_wr_sel = 2'd1; bank_wr_data = 8'h99;
    #2;
    chk("R2 same-cycle write uses old", bus_addr, {kv[1], 16'h0ABC});
    @(negedge clk);
    bank_wr_en = 0; kv[1] = 8'h99;
    op_fetch = 0; is_code = 1; last_cycle = 0;
    pfx(8'h83); instr("R2 new value next", 8'hAD, 8'h99);
  endtask

  initial begin
    t_reset;
    t_write;
    t_plain;
    t_prefix;
    t_double;
    t_dedic;
    t_pfx_dedic;
    t_abandon;
    t_collide;
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule